// File: doc/BRIEF.md
# Capture Channel Event Interrupt Status

This block keeps the sticky interrupt flags of a four-channel capture DMA engine. Each channel has five event sources: frame start, frame end, acknowledged frame end, line end and acknowledged line end. Each event arrives as a one-cycle strobe. The engine also raises shared events: a FIFO overflow and four kinds of discard. Every strobe that is allowed through sets one bit of a 32-bit status word.

The bits are grouped by event type. Each type owns a 4-bit field, and the channel number selects the bit inside that field. Software reads the status word and writes the same value back, which clears exactly the flags it has seen. Each channel has its own control word, which holds five enable bits, one per event type. A disabled event type never sets its flag. The interrupt line is high while any flag is set whose event type is currently enabled. Flags of shared events always count.

Top module: `frame_irq_status`

## Requirements
- R1: After reset the status word, every channel control word and `irq` are all zero.
- R2: Status bit positions are fixed. For channel x: frame start is bit x, frame end is bit 4+x, acknowledged frame end is bit 8+x, line end is bit 12+x and acknowledged line end is bit 16+x. Bits 25 to 31 always read 0.
- R3: A write to the status word (address 0) clears exactly the bits that are 1 in the written data. Every other bit keeps its value.
- R4: When an event strobe and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: The control word of channel x is at address 1+x. Its bits 13, 14, 15, 16 and 17 enable, in that order: frame start, frame end, acknowledged frame end, line end and acknowledged line end. A strobe whose enable bit is 0 leaves its status bit unchanged. All other control bits read 0.
- R6: The overflow strobe sets bit 20. Discard strobe d (0 to 3) sets bit 21+d. No enable bit gates these shared events.
- R7: `irq` is high exactly when a set status bit is enabled. A bit counts as enabled when its control enable bit is 1 now; shared bits 20 to 24 always count. Clearing an enable hides its flag from `irq` but does not clear the flag.
- R8: A strobe or write sampled at a rising clock edge shows up in `rdata` and `irq` directly after that edge. With no strobe and no write, the status word holds its value.
- R9: A write to an unmapped address (5 to 7) changes no register, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_fs | input | 4 | Frame start strobe, one bit per channel |
| ev_fe | input | 4 | Frame end strobe, one bit per channel |
| ev_fe_ack | input | 4 | Acknowledged frame end strobe, one bit per channel |
| ev_le | input | 4 | Line end strobe, one bit per channel |
| ev_le_ack | input | 4 | Acknowledged line end strobe, one bit per channel |
| ev_ovf | input | 1 | Shared FIFO overflow strobe |
| ev_disc | input | 4 | Shared discard strobes |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| irq | output | 1 | Interrupt request |

## Verification
Every result of this block is due in the cycle right after the edge that samples the stimulus. Flags, control words and `irq` are all visible there, because reads are combinational from the registers. The bench drives strobes and writes on the falling edge and holds them for one full cycle. It then samples `rdata` and `irq` on the next falling edge, half a cycle after the edge that used the stimulus. Hold behaviour is checked by sampling again after several idle cycles. The race between a strobe and a clearing write is checked by driving both in the same cycle.

// File: rtl/frame_irq_status.sv
module frame_irq_status #(
  parameter int NUM_CH   = 4,
  parameter int NUM_DISC = 4,
  parameter int DW       = 32,
  parameter int AW       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ev_fs,
  input  logic [NUM_CH-1:0] ev_fe,
  input  logic [NUM_CH-1:0] ev_fe_ack,
  input  logic [NUM_CH-1:0] ev_le,
  input  logic [NUM_CH-1:0] ev_le_ack,
  input  logic              ev_ovf,
  input  logic [NUM_DISC-1:0] ev_disc,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq
);
  localparam int GRP      = 4;
  localparam int NEVT     = 5;
  localparam int OVF_BIT  = NEVT * GRP;
  localparam int DISC_LSB = OVF_BIT + 1;
  localparam int EN_LSB   = 13;

  logic [NEVT-1:0] en_q [NUM_CH];
  logic [DW-1:0]   stat_q;
  logic [DW-1:0]   raw_v, allow_v, set_v, clr_v;
  logic            wr_stat;

  assign wr_stat = wr_en && (addr == '0);
  assign clr_v   = wr_stat ? wdata : '0;

  always_comb begin
    raw_v   = '0;
    allow_v = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      raw_v[0*GRP + ch] = ev_fs[ch];
      raw_v[1*GRP + ch] = ev_fe[ch];
      raw_v[2*GRP + ch] = ev_fe_ack[ch];
      raw_v[3*GRP + ch] = ev_le[ch];
      raw_v[4*GRP + ch] = ev_le_ack[ch];
      for (int k = 0; k < NEVT; k++)
        allow_v[k*GRP + ch] = en_q[ch][k];
    end
    raw_v[OVF_BIT]   = ev_ovf;
    allow_v[OVF_BIT] = 1'b1;
    for (int d = 0; d < NUM_DISC; d++) begin
      raw_v[DISC_LSB + d]   = ev_disc[d];
      allow_v[DISC_LSB + d] = 1'b1;
    end
  end

  assign set_v = raw_v & allow_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_v) | set_v;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) en_q[ch] <= '0;
      else if (wr_en && addr == AW'(ch + 1)) en_q[ch] <= wdata[EN_LSB +: NEVT];
  end

  always_comb begin
    rdata = '0;
    if (addr == '0) rdata = stat_q;
    for (int ch = 0; ch < NUM_CH; ch++)
      if (addr == AW'(ch + 1)) rdata[EN_LSB +: NEVT] = en_q[ch];
  end

  assign irq = |(stat_q & allow_v);
endmodule

module frame_irq_status_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] stat,
  input logic [DW-1:0] set_v,
  input logic [DW-1:0] clr_v,
  input logic [DW-1:0] allow_v,
  input logic          irq
);
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & $past(clr_v & ~set_v)) == '0));

  assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & $past(set_v)) == $past(set_v)));

  assert_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(allow_v)) == '0));

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v == '0 && clr_v == '0) |=> $stable(stat));
endmodule

bind frame_irq_status frame_irq_status_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stat(stat_q), .set_v(set_v),
  .clr_v(clr_v), .allow_v(allow_v), .irq(irq)
);

// File: tb/frame_irq_status_tb.sv
module frame_irq_status_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ev_fs = '0, ev_fe = '0, ev_fe_ack = '0, ev_le = '0, ev_le_ack = '0;
  logic        ev_ovf = 1'b0;
  logic [3:0]  ev_disc = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  localparam logic [31:0] ALL_EN = 32'h0003_E000;

  always #5 clk = ~clk;

  frame_irq_status u_dut (
    .clk(clk), .rst_n(rst_n), .ev_fs(ev_fs), .ev_fe(ev_fe), .ev_fe_ack(ev_fe_ack),
    .ev_le(ev_le), .ev_le_ack(ev_le_ack), .ev_ovf(ev_ovf), .ev_disc(ev_disc),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; addr = '0;
  endtask

  task automatic pulse(input int typ, input int ch);
    @(negedge clk);
    case (typ)
      0: ev_fs[ch] = 1'b1;
      1: ev_fe[ch] = 1'b1;
      2: ev_fe_ack[ch] = 1'b1;
      3: ev_le[ch] = 1'b1;
      4: ev_le_ack[ch] = 1'b1;
      5: ev_ovf = 1'b1;
      default: ev_disc[ch] = 1'b1;
    endcase
    @(negedge clk);
    ev_fs = '0; ev_fe = '0; ev_fe_ack = '0; ev_le = '0; ev_le_ack = '0;
    ev_ovf = 1'b0; ev_disc = '0;
  endtask

  task automatic clear_all();
    wr(3'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); check("R1 status", d, 0);
    for (int ch = 0; ch < 4; ch++) begin
      rd(3'(ch + 1), d); check("R1 ctrl", d, 0);
    end
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    for (int ch = 0; ch < 4; ch++) wr(3'(ch + 1), ALL_EN);
    rd(3'd2, d); check("R5 ctrl readback", d, ALL_EN);
    for (int ch = 0; ch < 4; ch++)
      for (int k = 0; k < 5; k++) begin
        pulse(k, ch);
        rd(3'd0, d);
        check("R2 bit map", d, 32'd1 << (4 * k + ch));
        check("R8 irq after edge", {31'd0, irq}, 1);
        wr(3'd0, d);
        rd(3'd0, d);
        check("R3 write-back clears", d, 0);
      end
  endtask

  task automatic t_gate();
    logic [31:0] d;
    for (int ch = 0; ch < 4; ch++) wr(3'(ch + 1), 0);
    wr(3'd3, 32'h0000_8000);
    for (int k = 0; k < 5; k++) pulse(k, 2);
    for (int k = 0; k < 5; k++) pulse(k, 1);
    rd(3'd0, d);
    check("R5 only enabled type of ch2", d, 32'h0000_0400);
    check("R5 irq", {31'd0, irq}, 1);
    clear_all();
  endtask

  task automatic t_global();
    logic [31:0] d;
    pulse(5, 0);
    rd(3'd0, d); check("R6 overflow bit 20", d, 32'h0010_0000);
    check("R6 irq without enables", {31'd0, irq}, 1);
    for (int dd = 0; dd < 4; dd++) pulse(6, dd);
    rd(3'd0, d); check("R6 discard bits 21-24", d, 32'h01F0_0000);
    clear_all();
    rd(3'd0, d); check("R3 clear global", d, 0);
    check("R7 irq low when empty", {31'd0, irq}, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    for (int ch = 0; ch < 4; ch++) wr(3'(ch + 1), ALL_EN);
    pulse(0, 0); pulse(1, 3); pulse(3, 1); pulse(5, 0);
    rd(3'd0, d); check("R2 mixed", d, 32'h0010_2081);
    wr(3'd0, 32'hFE00_2001);
    rd(3'd0, d); check("R3 partial clear", d, 32'h0010_0080);
    repeat (5) @(negedge clk);
    rd(3'd0, d); check("R8 hold idle", d, 32'h0010_0080);
    clear_all();
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse(2, 1); pulse(4, 0);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd0; wdata = 32'h0001_0200; ev_fe_ack[1] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; ev_fe_ack = '0;
    rd(3'd0, d); check("R4 event beats clear", d, 32'h0000_0200);
    clear_all();
  endtask

  task automatic t_irq_mask();
    logic [31:0] d;
    pulse(3, 2);
    check("R7 irq set", {31'd0, irq}, 1);
    wr(3'd3, 0);
    rd(3'd0, d); check("R7 flag kept", d, 32'h0000_4000);
    check("R7 irq hidden", {31'd0, irq}, 0);
    wr(3'd3, ALL_EN);
    check("R7 irq back", {31'd0, irq}, 1);
    clear_all();
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); check("R5 unused ctrl bits", d, ALL_EN);
    wr(3'd1, 0);
    pulse(1, 1);
    for (int a = 5; a < 8; a++) wr(3'(a), 32'hFFFF_FFFF);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), d); check("R9 unmapped reads 0", d, 0);
    end
    rd(3'd1, d); check("R9 ctrl ch0 untouched", d, 0);
    rd(3'd0, d); check("R9 status untouched", d, 32'h0000_0020);
    wr(3'd0, 32'hFE00_0000);
    rd(3'd0, d); check("R2 upper bits", d, 32'h0000_0020);
    clear_all();
  endtask

  initial begin
    fork
      begin
        #3 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_gate();
        t_global();
        t_w1c();
        t_race();
        t_irq_mask();
        t_unmapped();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule